// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block decides which analog input a converter samples next, and when it stops. Software sets a start bit, picks one of four modes with a 2-bit code, and supplies a channel-enable mask, a differential-input switch and a signed-output switch. The sequencer then issues conversion requests to the converter, one channel at a time. It accepts each 12-bit result and files it in a per-channel result slot. Each slot has a valid flag and an overrun flag, and both clear when the slot is read.

The converter side is two streams. On the request stream (`req_valid`/`req_ready`/`req_chan`) the sequencer holds `req_valid` and `req_chan` steady until the converter takes them. On the response stream (`rsp_valid`/`rsp_ready`/`rsp_data`) the sequencer raises `rsp_ready` only while it waits for a result. The converter must hold `rsp_valid` and `rsp_data` until `rsp_ready` is high. The sequencer never takes more than one request in flight. When software stops a run, `conv_flush` pulses so that the converter drops any pending work.

Top module: `adc_seq_top`

## Requirements
- R1: Mode code 0 (single) converts only the lowest enabled channel once. It then sets `eoc` and clears the start bit by itself.
- R2: Mode code 2 (one pass) converts every enabled channel once, in ascending index order. It sets `eoc` after the last one and then clears the start bit by itself.
- R3: Mode code 3 (continuous) wraps from the highest enabled channel back to the lowest and sets `eoc` at the end of each pass. `busy` stays high until software writes 0 to the start bit.
- R4: Mode code 1 (burst) converts the lowest enabled channel over and over and writes every result to slot 0. `eoc` sets when 8 results have been written since the start or since slot 0 was last read.
- R5: A write to a slot sets its valid flag. A read (`rd_en`) returns the slot's data and flags in the same cycle, then clears both flags, unless a new result lands in that slot in the same cycle.
- R6: A result written into a slot whose valid flag is still set also sets that slot's overrun flag.
- R7: Only mask bits 0 to 15 and bit 29 can enable a channel; every other mask bit is ignored. A start with no usable channel makes no request and drops `busy` again.
- R8: With `diff_en` high, odd mask bits are ignored, so only even channels 0 to 14 are converted, each into its own slot. With `signed_fmt` also high, the result MSB is inverted (offset binary to two's complement).
- R9: `busy` follows the start bit. While busy, `cur_chan` shows the channel in conversion. While idle, it shows the lowest usable enabled channel, or 0 if there is none.
- R10: Pulsing `eoc_clr` clears `eoc`. If the block sets `eoc` in the same cycle, the set wins.
- R11: Writing 0 to the start bit stops the block within one clock: `busy`, `req_valid` and `rsp_ready` go low, `conv_flush` pulses, and a result arriving in that cycle is discarded.
- R12: `any_valid` and `any_overrun` are the OR of the valid flags and of the overrun flags across all slots.
- R13: While `req_ready` is low, a raised `req_valid` stays high and `req_chan` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_wr | input | 1 | Write strobe for the start bit |
| start_wdata | input | 1 | Value written to the start bit |
| mode | input | 2 | 0 single, 1 burst, 2 one pass, 3 continuous |
| chan_mask | input | 32 | Channel enable mask |
| diff_en | input | 1 | Differential input pairing |
| signed_fmt | input | 1 | Two's complement output in differential mode |
| eoc_clr | input | 1 | Write-one-to-clear pulse for eoc |
| rd_en | input | 1 | Result slot read strobe |
| rd_slot | input | 5 | Slot index to read |
| rd_data | output | 12 | Data of the addressed slot |
| rd_valid | output | 1 | Valid flag of the addressed slot |
| rd_overrun | output | 1 | Overrun flag of the addressed slot |
| busy | output | 1 | Start bit state |
| cur_chan | output | 5 | Active or next channel |
| eoc | output | 1 | End-of-conversion flag |
| any_valid | output | 1 | OR of all valid flags |
| any_overrun | output | 1 | OR of all overrun flags |
| req_valid | output | 1 | Conversion request valid |
| req_ready | input | 1 | Converter accepts request |
| req_chan | output | 5 | Channel to convert |
| rsp_valid | input | 1 | Result valid |
| rsp_ready | output | 1 | Sequencer accepts result |
| rsp_data | input | 12 | Raw converter result |
| conv_flush | output | 1 | Converter abort pulse |

## Verification
The assertions assume that mode, mask, `diff_en` and `signed_fmt` stay stable while `busy` is high. They also assume that the converter never presents a result unless it accepted a request and has not been flushed since. The stimulus changes configuration only after `busy` has dropped, or after an explicit stop. It drives the converter from a model that holds each result until `rsp_ready` and clears itself on `conv_flush`. That model also has a stall input, used to keep `req_ready` low for several cycles so that request hold can be observed.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    MD_SINGLE    = 2'd0,
    MD_BURST     = 2'd1,
    MD_SCAN_ONCE = 2'd2,
    MD_SCAN_LOOP = 2'd3
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NCH = 32,
  parameter int CW  = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  output logic           found,
  output logic [CW-1:0]  idx
);
  // lowest set bit wins: scan from the top so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = CW'(i);
      end
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH = 32,
  parameter int CW  = $clog2(NCH),
  parameter int DW  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [CW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_overrun,
  output logic          any_valid,
  output logic          any_overrun
);
  logic [DW-1:0]  dat [NCH];
  logic [NCH-1:0] vld;
  logic [NCH-1:0] ovr;

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    logic wr_hit, rd_hit;
    assign wr_hit = wr_en && (wr_idx == CW'(g));
    assign rd_hit = rd_en && (rd_idx == CW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dat[g] <= '0;
        vld[g] <= 1'b0;
        ovr[g] <= 1'b0;
      end else if (wr_hit) begin
        dat[g] <= wr_data;
        vld[g] <= 1'b1;
        ovr[g] <= vld[g] && !rd_hit;
      end else if (rd_hit) begin
        vld[g] <= 1'b0;
        ovr[g] <= 1'b0;
      end
    end
  end

  assign rd_data     = dat[rd_idx];
  assign rd_valid    = vld[rd_idx];
  assign rd_overrun  = ovr[rd_idx];
  assign any_valid   = |vld;
  assign any_overrun = |ovr;

  p_write_sets_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld[$past(wr_idx)]);

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !(wr_en && wr_idx == rd_idx)) |=> (!vld[$past(rd_idx)] && !ovr[$past(rd_idx)]));

  p_overwrite_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && vld[wr_idx] && !(rd_en && rd_idx == wr_idx)) |=> ovr[$past(wr_idx)]);

  p_overrun_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr & ~vld) == '0);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH       = 32,
  parameter int CW        = $clog2(NCH),
  parameter int BURST_THR = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_wr,
  input  logic           start_wdata,
  input  logic [1:0]     mode,
  input  logic [NCH-1:0] eff_mask,
  input  logic           eoc_clr,
  input  logic           slot0_rd,
  output logic           run,
  output logic [CW-1:0]  cur_chan,
  output logic           eoc,
  output logic           req_valid,
  input  logic           req_ready,
  output logic [CW-1:0]  req_chan,
  input  logic           rsp_valid,
  output logic           rsp_ready,
  output logic           wr_en,
  output logic [CW-1:0]  wr_idx,
  output logic           flush
);
  localparam int BW = $clog2(BURST_THR + 1);

  seq_mode_e      md;
  seq_state_e     state;
  logic [CW-1:0]  act;
  logic [BW-1:0]  bcnt, bnext;
  logic [NCH-1:0] above, next_mask;
  logic           first_found, next_found;
  logic [CW-1:0]  first_idx, next_idx;
  logic           abort, go, rsp_hs;

  assign md     = seq_mode_e'(mode);
  assign abort  = start_wr && !start_wdata;
  assign go     = start_wr && start_wdata && !run;
  assign rsp_hs = (state == ST_WAIT) && rsp_valid;

  always_comb begin
    for (int i = 0; i < NCH; i++) above[i] = (i > int'(act));
  end
  assign next_mask = eff_mask & above;

  adc_chan_pick #(.NCH(NCH), .CW(CW)) i_first (
    .mask(eff_mask), .found(first_found), .idx(first_idx));
  adc_chan_pick #(.NCH(NCH), .CW(CW)) i_next (
    .mask(next_mask), .found(next_found), .idx(next_idx));

  always_comb begin
    if (slot0_rd)                         bnext = BW'(1);
    else if (bcnt >= BW'(BURST_THR))      bnext = bcnt;
    else                                  bnext = bcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      run   <= 1'b0;
      act   <= '0;
      eoc   <= 1'b0;
      bcnt  <= '0;
    end else begin
      if (eoc_clr)  eoc  <= 1'b0;
      if (slot0_rd) bcnt <= '0;
      if (abort) begin
        run   <= 1'b0;
        state <= ST_IDLE;
      end else begin
        if (go) begin
          run  <= 1'b1;
          bcnt <= '0;
        end
        unique case (state)
          ST_IDLE: begin
            if (run) begin
              if (first_found) begin
                state <= ST_REQ;
                act   <= first_idx;
              end else begin
                run <= 1'b0;
              end
            end
          end
          ST_REQ: begin
            if (req_ready) state <= ST_WAIT;
          end
          ST_WAIT: begin
            if (rsp_valid) begin
              unique case (md)
                MD_SINGLE: begin
                  eoc   <= 1'b1;
                  run   <= 1'b0;
                  state <= ST_IDLE;
                end
                MD_BURST: begin
                  bcnt <= bnext;
                  if (bnext >= BW'(BURST_THR)) eoc <= 1'b1;
                  if (first_found) begin
                    act   <= first_idx;
                    state <= ST_REQ;
                  end else begin
                    run   <= 1'b0;
                    state <= ST_IDLE;
                  end
                end
                default: begin
                  if (next_found) begin
                    act   <= next_idx;
                    state <= ST_REQ;
                  end else begin
                    eoc <= 1'b1;
                    if (md == MD_SCAN_ONCE || !first_found) begin
                      run   <= 1'b0;
                      state <= ST_IDLE;
                    end else begin
                      act   <= first_idx;
                      state <= ST_REQ;
                    end
                  end
                end
              endcase
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign req_valid = (state == ST_REQ);
  assign rsp_ready = (state == ST_WAIT);
  assign req_chan  = act;
  assign cur_chan  = (state == ST_IDLE) ? (first_found ? first_idx : '0) : act;
  assign wr_en     = rsp_hs && !abort;
  assign wr_idx    = (md == MD_BURST) ? '0 : act;
  assign flush     = abort;

  p_single_autostop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hs && md == MD_SINGLE && !start_wr) |=> (!run && eoc));

  p_once_autostop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hs && md == MD_SCAN_ONCE && !next_found && !start_wr) |=> (!run && eoc));

  p_loop_keeps_running_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && state != ST_IDLE && md == MD_SCAN_LOOP && !start_wr) |=> run);

  p_eoc_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_clr && !rsp_hs) |=> !eoc);

  p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!run && !req_valid && !rsp_ready));

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !start_wr) |=> (req_valid && $stable(req_chan)));
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int              NCH        = 32,
  parameter int              CW         = $clog2(NCH),
  parameter int              DW         = 12,
  parameter int              BURST_THR  = 8,
  parameter logic [NCH-1:0]  LEGAL_MASK = 32'h2000_FFFF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_wr,
  input  logic           start_wdata,
  input  logic [1:0]     mode,
  input  logic [NCH-1:0] chan_mask,
  input  logic           diff_en,
  input  logic           signed_fmt,
  input  logic           eoc_clr,
  input  logic           rd_en,
  input  logic [CW-1:0]  rd_slot,
  output logic [DW-1:0]  rd_data,
  output logic           rd_valid,
  output logic           rd_overrun,
  output logic           busy,
  output logic [CW-1:0]  cur_chan,
  output logic           eoc,
  output logic           any_valid,
  output logic           any_overrun,
  output logic           req_valid,
  input  logic           req_ready,
  output logic [CW-1:0]  req_chan,
  input  logic           rsp_valid,
  output logic           rsp_ready,
  input  logic [DW-1:0]  rsp_data,
  output logic           conv_flush
);
  function automatic logic [NCH-1:0] even_bits();
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[i] = (i % 2 == 0);
    return v;
  endfunction

  localparam logic [NCH-1:0] EVEN_MASK = even_bits();
  localparam logic [DW-1:0]  MSB_FLIP  = DW'(1) << (DW - 1);

  logic [NCH-1:0] eff_mask;
  logic [DW-1:0]  wr_data;
  logic           wr_en, slot0_rd;
  logic [CW-1:0]  wr_idx;

  assign eff_mask = chan_mask & LEGAL_MASK & (diff_en ? EVEN_MASK : '1);
  assign wr_data  = rsp_data ^ ((diff_en && signed_fmt) ? MSB_FLIP : '0);
  assign slot0_rd = rd_en && (rd_slot == '0);

  adc_seq_ctrl #(.NCH(NCH), .CW(CW), .BURST_THR(BURST_THR)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_wr(start_wr), .start_wdata(start_wdata),
    .mode(mode), .eff_mask(eff_mask), .eoc_clr(eoc_clr), .slot0_rd(slot0_rd),
    .run(busy), .cur_chan(cur_chan), .eoc(eoc),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .wr_en(wr_en), .wr_idx(wr_idx), .flush(conv_flush));

  adc_result_bank #(.NCH(NCH), .CW(CW), .DW(DW)) i_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_slot),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_overrun(rd_overrun),
    .any_valid(any_valid), .any_overrun(any_overrun));

  p_legal_chan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> LEGAL_MASK[req_chan]);

  p_diff_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && diff_en) |-> !req_chan[0]);

  p_busy_follows_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && start_wdata) |=> busy);

  p_idle_no_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!req_valid && !rsp_ready));
endmodule

// File: tb/adc_conv_model.sv
module adc_conv_model #(
  parameter int CW  = 5,
  parameter int DW  = 12,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          stall,
  input  logic          req_valid,
  input  logic [CW-1:0] req_chan,
  output logic          req_ready,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data
);
  logic          pend;
  int            cnt;
  logic [CW-1:0] ch;

  assign req_ready = !pend && !stall;
  assign rsp_valid = pend && (cnt == 0);
  assign rsp_data  = DW'(int'(ch) * 37 + 5);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      pend <= 1'b0;
      cnt  <= 0;
      ch   <= '0;
    end else if (!pend) begin
      if (req_valid && req_ready) begin
        pend <= 1'b1;
        cnt  <= LAT;
        ch   <= req_chan;
      end
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
    end else if (rsp_ready) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: tb/test_adc_seq_top.sv
module test_adc_seq_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_wr, start_wdata, diff_en, signed_fmt, eoc_clr, rd_en, stall;
  logic [1:0]  mode;
  logic [31:0] chan_mask;
  logic [4:0]  rd_slot, cur_chan, req_chan;
  logic [11:0] rd_data, rsp_data;
  logic        rd_valid, rd_overrun, busy, eoc, any_valid, any_overrun;
  logic        req_valid, req_ready, rsp_valid, rsp_ready, conv_flush;

  always #2.5 clk = ~clk;

  adc_seq_top i_adc_seq_top (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_wdata(start_wdata),
    .mode(mode), .chan_mask(chan_mask), .diff_en(diff_en), .signed_fmt(signed_fmt),
    .eoc_clr(eoc_clr), .rd_en(rd_en), .rd_slot(rd_slot), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_overrun(rd_overrun), .busy(busy), .cur_chan(cur_chan),
    .eoc(eoc), .any_valid(any_valid), .any_overrun(any_overrun),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .conv_flush(conv_flush));

  adc_conv_model #(.CW(5), .DW(12), .LAT(4)) i_model (
    .clk(clk), .rst_n(rst_n), .flush(conv_flush), .stall(stall),
    .req_valid(req_valid), .req_chan(req_chan), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data));

  // request log and response counter
  logic [4:0] log_q [256];
  int nlog, nrsp;
  always @(posedge clk) begin
    if (!rst_n) begin
      nlog <= 0;
      nrsp <= 0;
    end else begin
      if (req_valid && req_ready) begin
        log_q[nlog % 256] <= req_chan;
        nlog <= nlog + 1;
      end
      if (rsp_valid && rsp_ready) nrsp <= nrsp + 1;
    end
  end

  typedef struct packed {
    logic [1:0]  md;
    logic [31:0] mask;
    logic        dif;
    logic        sgn;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 32'h0000_0030, 1'b0, 1'b0},
    '{2'd2, 32'h0000_00A5, 1'b0, 1'b0},
    '{2'd2, 32'hC001_8001, 1'b0, 1'b0},
    '{2'd2, 32'h2000_0102, 1'b0, 1'b0},
    '{2'd2, 32'h2000_00FF, 1'b1, 1'b0},
    '{2'd2, 32'h0000_0F0C, 1'b1, 1'b1},
    '{2'd0, 32'h0000_0002, 1'b1, 1'b0},
    '{2'd0, 32'h2000_0000, 1'b0, 1'b0}
  };

  int  n_chk = 0, n_bad = 0;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic start_bit(input bit v);
    start_wr = 1'b1; start_wdata = v;
    @(negedge clk);
    start_wr = 1'b0; start_wdata = 1'b0;
  endtask

  task automatic clear_eoc();
    eoc_clr = 1'b1;
    @(negedge clk);
    eoc_clr = 1'b0;
  endtask

  task automatic read_slot(input int s, output int d, output int v, output int o);
    rd_en = 1'b1; rd_slot = 5'(s);
    #1;
    d = int'(rd_data); v = int'(rd_valid); o = int'(rd_overrun);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int t = 0;
    while (busy && t < 2000) begin @(negedge clk); t++; end
    chk(t < 2000, tag, "run did not stop", t, 2000);
  endtask

  function automatic logic [31:0] usable(input logic [31:0] m, input logic d);
    logic [31:0] u = m & 32'h2000_FFFF;
    if (d) u = u & 32'h0000_5555;
    return u;
  endfunction

  function automatic int conv_val(input int ch, input logic flip);
    int v = (ch * 37 + 5) & 12'hFFF;
    if (flip) v = v ^ 12'h800;
    return v;
  endfunction

  initial begin
    int d, v, o, base, rb, k, t;
    logic [31:0] es;
    string tg;
    rst_n = 1'b0; start_wr = 1'b0; start_wdata = 1'b0; mode = 2'd0;
    chan_mask = '0; diff_en = 1'b0; signed_fmt = 1'b0; eoc_clr = 1'b0;
    rd_en = 1'b0; rd_slot = '0; stall = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(busy == 1'b0, "R9", "busy after reset", int'(busy), 0);
    chk(eoc == 1'b0, "R10", "eoc after reset", int'(eoc), 0);
    chk(any_valid == 1'b0 && any_overrun == 1'b0, "R12", "summary flags after reset",
        int'({any_valid, any_overrun}), 0);
    chk(req_valid == 1'b0, "R13", "req_valid after reset", int'(req_valid), 0);
    chk(cur_chan == 5'd0, "R9", "cur_chan with empty mask", int'(cur_chan), 0);

    // table walk: single, one-pass and differential runs
    for (int n = 0; n < 8; n++) begin
      mode = VEC[n].md; chan_mask = VEC[n].mask;
      diff_en = VEC[n].dif; signed_fmt = VEC[n].sgn;
      clear_eoc();
      es = usable(VEC[n].mask, VEC[n].dif);
      if (VEC[n].md == 2'd0) es = es & (~es + 32'd1);
      tg = VEC[n].dif ? "R8" : ((VEC[n].md == 2'd0) ? "R1" : "R2");
      base = nlog;
      start_bit(1'b1);
      wait_idle(tg);
      chk(eoc == (es != 0), tg, "eoc at end of run", int'(eoc), int'(es != 0));
      chk(nlog - base == $countones(es), "R7", "request count", nlog - base, $countones(es));
      k = 0;
      for (int c = 0; c < 32; c++) begin
        if (es[c]) begin
          chk(log_q[(base + k) % 256] == 5'(c), "R2", "request order",
              int'(log_q[(base + k) % 256]), c);
          k++;
        end
      end
      for (int c = 0; c < 32; c++) begin
        read_slot(c, d, v, o);
        chk(v == int'(es[c]), "R7", "slot valid map", v, int'(es[c]));
        chk(o == 0, "R6", "no overrun on single write", o, 0);
        if (es[c]) chk(d == conv_val(c, VEC[n].dif & VEC[n].sgn), "R5", "slot data", d,
                       conv_val(c, VEC[n].dif & VEC[n].sgn));
      end
    end
    diff_en = 1'b0; signed_fmt = 1'b0;

    // cur_chan while idle and while busy; request held under stall
    mode = 2'd0; chan_mask = 32'h0000_0030;
    @(negedge clk);
    chk(cur_chan == 5'd4, "R9", "cur_chan idle shows next", int'(cur_chan), 4);
    stall = 1'b1;
    start_bit(1'b1);
    @(negedge clk);
    chk(busy == 1'b1, "R9", "busy follows start", int'(busy), 1);
    chk(req_valid == 1'b1 && req_chan == 5'd4, "R13", "request raised", int'(req_chan), 4);
    repeat (5) @(negedge clk);
    chk(req_valid == 1'b1 && req_chan == 5'd4, "R13", "request held under stall",
        int'(req_valid), 1);
    chk(cur_chan == 5'd4, "R9", "cur_chan while busy", int'(cur_chan), 4);
    stall = 1'b0;
    wait_idle("R1");
    read_slot(4, d, v, o);
    clear_eoc();

    // continuous scan, then stop
    mode = 2'd3; chan_mask = 32'h0000_0006;
    base = nlog; rb = nrsp;
    start_bit(1'b1);
    t = 0;
    while (nrsp - rb < 5 && t < 2000) begin @(negedge clk); t++; end
    chk(busy == 1'b1, "R3", "busy during continuous scan", int'(busy), 1);
    chk(eoc == 1'b1, "R3", "eoc after a pass", int'(eoc), 1);
    for (int j = 0; j < 5; j++)
      chk(log_q[(base + j) % 256] == ((j % 2 == 0) ? 5'd1 : 5'd2), "R3", "wrap order",
          int'(log_q[(base + j) % 256]), (j % 2 == 0) ? 1 : 2);
    start_wr = 1'b1; start_wdata = 1'b0;
    #1;
    chk(conv_flush == 1'b1, "R11", "flush on stop", int'(conv_flush), 1);
    @(negedge clk);
    start_wr = 1'b0;
    chk(busy == 1'b0 && req_valid == 1'b0 && rsp_ready == 1'b0, "R11", "idle one clock after stop",
        int'({busy, req_valid, rsp_ready}), 0);
    chk(any_overrun == 1'b1, "R12", "any_overrun set", int'(any_overrun), 1);
    read_slot(1, d, v, o);
    chk(v == 1 && o == 1, "R6", "slot 1 overwritten", o, 1);
    read_slot(2, d, v, o);
    chk(v == 1 && o == 1, "R6", "slot 2 overwritten", o, 1);
    chk(any_valid == 1'b0 && any_overrun == 1'b0, "R12", "summary after reads",
        int'({any_valid, any_overrun}), 0);

    // eoc write-one-to-clear
    chk(eoc == 1'b1, "R10", "eoc still set", int'(eoc), 1);
    clear_eoc();
    chk(eoc == 1'b0, "R10", "eoc cleared", int'(eoc), 0);

    // burst into slot 0
    mode = 2'd1; chan_mask = 32'h0000_0008;
    rb = nrsp;
    start_bit(1'b1);
    t = 0;
    while (nrsp - rb < 7 && t < 2000) begin @(negedge clk); t++; end
    chk(eoc == 1'b0, "R4", "eoc after 7 burst results", int'(eoc), 0);
    while (nrsp - rb < 8 && t < 4000) begin @(negedge clk); t++; end
    chk(eoc == 1'b1, "R4", "eoc after 8 burst results", int'(eoc), 1);
    chk(busy == 1'b1, "R4", "burst keeps running", int'(busy), 1);
    start_bit(1'b0);
    read_slot(3, d, v, o);
    chk(v == 0, "R4", "burst leaves own slot empty", v, 0);
    read_slot(0, d, v, o);
    chk(v == 1 && o == 1 && d == conv_val(3, 1'b0), "R4", "burst data in slot 0", d, conv_val(3, 1'b0));
    clear_eoc();

    // repeated single runs without a read
    mode = 2'd0; chan_mask = 32'h0000_0001;
    start_bit(1'b1);
    wait_idle("R1");
    chk(any_valid == 1'b1, "R12", "any_valid after a result", int'(any_valid), 1);
    start_bit(1'b1);
    wait_idle("R1");
    read_slot(0, d, v, o);
    chk(v == 1 && o == 1 && d == 5, "R6", "overrun after unread rewrite", o, 1);
    read_slot(0, d, v, o);
    chk(v == 0 && o == 0, "R5", "flags cleared by read", v + o, 0);

    // empty usable mask
    chan_mask = 32'hC000_0000; base = nlog;
    start_bit(1'b1);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && nlog == base, "R7", "no request for ignored bits", nlog - base, 0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule